// File: doc/BRIEF.md
# LIN Bus Dominant Timeout Guard

This block supervises the transmit side of a single-wire LIN transceiver. It samples the bus level through a synchroniser and counts the clock cycles for which the bus has been low without a break. When that count reaches a parameterised limit, the guard turns off the transmitter and disconnects the bus pull-up. It also holds the receive line toward the microcontroller high, so a stuck bus cannot look like an endless stream of dominant bits.

The timer watches only the bus level. A low level counts in the same way whether the local TXD request or another node on the bus pulls it low. A high level ends the run whatever produced it. A second block resolves the two digital control pins to safe values when nothing drives them: an undriven chip-select disables the transmitter, and an undriven TXD reads as recessive. The recovery is immediate. In the first cycle in which the synchronised bus reads high again, the transmitter enable and the pull-up come back, and RXD follows the bus again.

Top module: `lin_dom_guard`

## Requirements
- R1: After TIMEOUT_CYC consecutive clock edges at which the synchronised bus sample is low (0), `tx_en` goes low while the synchronised sample stays low. A run of TIMEOUT_CYC-1 low samples leaves it unaffected.
- R2: While the guard is tripped and the synchronised sample is low, `rxd` is high (1).
- R3: `pullup_en` is low exactly while the guard is tripped and the synchronised sample is low. At all other times it is high.
- R4: A high synchronised sample at any clock edge restarts the low-run count from zero. An asserted `por_n` (active low, asynchronous) also restarts it.
- R5: A low bus level is timed identically whether TXD is low or the bus is pulled low externally while TXD is high.
- R6: `tx_en` is low whenever the resolved chip-select is low. When `cs_driven` is 0, the resolved chip-select is 0. Otherwise it equals `cs_in`.
- R7: When `txd_driven` is 0, the resolved TXD is 1. Otherwise it equals `txd_in`. `tx_dom` is high only when `tx_en` is high and the resolved TXD is 0.
- R8: After a trip, `tx_en` (subject to R6), `pullup_en` and `rxd` are restored in the first cycle in which the synchronised sample is high.
- R9: When the guard is not tripped, `rxd` equals `bus_in` as sampled SYNC_STAGES clock edges earlier (two by default).
- R10: While `por_n` is low, the synchroniser stages read high, so `rxd` is 1, `pullup_en` is 1 and `tx_en` equals the resolved chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervision clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| txd_in | input | 1 | Transmit data from the microcontroller (0 = dominant) |
| txd_driven | input | 1 | 1 when something actively drives the TXD pin |
| cs_in | input | 1 | Chip-select / transmitter enable request |
| cs_driven | input | 1 | 1 when something actively drives the chip-select pin |
| bus_in | input | 1 | Raw comparator sample of the bus level (0 = dominant) |
| tx_en | output | 1 | Transmitter enable |
| tx_dom | output | 1 | Command to the driver to pull the bus dominant |
| pullup_en | output | 1 | Connects the bus pull-up to the battery rail |
| rxd | output | 1 | Received level toward the microcontroller |

## Verification
The hardest state to reach is the boundary of the low run. The bus has to stay low at exactly TIMEOUT_CYC-1 and at exactly TIMEOUT_CYC synchronised samples, and the recessive edge that re-arms the guard has to be seen two cycles late through the synchroniser. The bench uses a short timeout and sweeps the low-burst length from zero to beyond the limit. It runs the sweep twice, once with the local TXD pulling low and once with TXD high and an external node pulling low. A cycle-level model of the synchroniser delay and the saturating run length predicts every output on every cycle. A reset in the middle of a run checks that a partial count is discarded.

// File: rtl/lin_guard_pkg.sv
package lin_guard_pkg;

  // Bus level encoding: 0 = dominant, 1 = recessive.
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  // Width that holds values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // True when this dominant sample completes the timeout window.
  function automatic logic run_completes(input int unsigned run_so_far,
                                         input int unsigned limit);
    return (run_so_far + 1) >= limit;
  endfunction

  // Pad resolution: undriven pins fall back to their fail-safe value.
  function automatic logic pad_resolve(input logic val, input logic driven,
                                       input logic safe_val);
    return driven ? val : safe_val;
  endfunction

endpackage

// File: rtl/lin_pin_failsafe.sv
module lin_pin_failsafe
  import lin_guard_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic txd_in,
  input  logic txd_driven,
  input  logic cs_in,
  input  logic cs_driven,
  output logic txd_res,
  output logic cs_res
);

  // TXD floats recessive; chip-select floats to disabled.
  assign txd_res = pad_resolve(txd_in, txd_driven, LVL_REC);
  assign cs_res  = pad_resolve(cs_in, cs_driven, 1'b0);

  AST_TXD_FLOAT_REC: assert property (@(posedge clk) disable iff (!por_n)
    !txd_driven |-> txd_res) else $error("txd float"); // R7
  AST_CS_FLOAT_OFF: assert property (@(posedge clk) disable iff (!por_n)
    !cs_driven |-> !cs_res) else $error("cs float"); // R6

endmodule

// File: rtl/lin_bus_sync.sv
module lin_bus_sync
  import lin_guard_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic bus_raw,
  output logic bus_sync
);

  logic [STAGES-1:0] stg;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          stg[gi] <= LVL_REC;
        end else if (gi == 0) begin
          stg[gi] <= bus_raw;
        end else begin
          stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign bus_sync = stg[STAGES-1];

  AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (bus_sync == $past(stg[(STAGES > 1) ? STAGES-2 : 0]) || STAGES == 1))
    else $error("sync shift"); // R9

endmodule

// File: rtl/lin_dom_timer.sv
module lin_dom_timer
  import lin_guard_pkg::*;
#(
  parameter int unsigned LIMIT = 5_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic bus_sync,
  output logic tripped,
  output logic trip_event,
  output logic rearm_event
);

  localparam int unsigned CW = cnt_width(LIMIT);

  logic [CW-1:0] run_cnt;
  logic          dom_now;
  logic          hit;

  assign dom_now     = (bus_sync == LVL_DOM);
  assign hit         = dom_now && !tripped && run_completes(32'(run_cnt), LIMIT);
  assign trip_event  = hit;
  assign rearm_event = !dom_now && (tripped || run_cnt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (!dom_now) begin
      run_cnt <= '0;
      tripped <= 1'b0;
    end else if (!tripped) begin
      if (hit) begin
        tripped <= 1'b1;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    32'(run_cnt) < LIMIT) else $error("count overflow"); // R1
  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!por_n)
    trip_event |=> tripped) else $error("trip lost"); // R1
  AST_REC_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !dom_now |=> (!tripped && run_cnt == '0)) else $error("no clear"); // R4
  AST_TRIP_NEEDS_DOM: assert property (@(posedge clk) disable iff (!por_n)
    $rose(tripped) |-> $past(dom_now)) else $error("bad trip"); // R1

endmodule

// File: rtl/lin_dom_guard.sv
module lin_dom_guard
  import lin_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic txd_in,
  input  logic txd_driven,
  input  logic cs_in,
  input  logic cs_driven,
  input  logic bus_in,
  output logic tx_en,
  output logic tx_dom,
  output logic pullup_en,
  output logic rxd
);

  logic txd_res, cs_res, bus_s;
  logic tripped, trip_event, rearm_event;
  logic guard_on;

  lin_pin_failsafe u_pins (
    .clk(clk), .por_n(por_n),
    .txd_in(txd_in), .txd_driven(txd_driven),
    .cs_in(cs_in), .cs_driven(cs_driven),
    .txd_res(txd_res), .cs_res(cs_res)
  );

  lin_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .bus_raw(bus_in), .bus_sync(bus_s)
  );

  lin_dom_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .por_n(por_n), .bus_sync(bus_s),
    .tripped(tripped), .trip_event(trip_event), .rearm_event(rearm_event)
  );

  // Guard holds only while the bus still reads dominant; a recessive
  // synchronised sample releases the outputs in the same cycle.
  assign guard_on  = tripped && (bus_s == LVL_DOM);
  assign tx_en     = cs_res && !guard_on;
  assign tx_dom    = tx_en && (txd_res == LVL_DOM);
  assign pullup_en = !guard_on;
  assign rxd       = guard_on ? LVL_REC : bus_s;

  AST_RXD_REC_GUARD: assert property (@(posedge clk) disable iff (!por_n)
    guard_on |-> rxd) else $error("rxd not recessive"); // R2
  AST_PULLUP_OFF: assert property (@(posedge clk) disable iff (!por_n)
    guard_on |-> (!pullup_en && !tx_en)) else $error("guard leak"); // R3
  AST_TX_NEEDS_CS: assert property (@(posedge clk) disable iff (!por_n)
    !cs_res |-> !tx_en) else $error("tx without cs"); // R6
  AST_DOM_NEEDS_TXD: assert property (@(posedge clk) disable iff (!por_n)
    tx_dom |-> (!txd_res && tx_en)) else $error("spurious dominant"); // R7
  AST_REARM_RESTORES: assert property (@(posedge clk) disable iff (!por_n)
    (tripped && bus_s) |-> (pullup_en && rxd)) else $error("rearm late"); // R8
  AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!por_n)
    (trip_event && !bus_in) |=> !pullup_en || bus_s) else $error("trip slow"); // R1

endmodule

// File: tb/sim_lin_dom_guard.sv
`timescale 1ns/1ps
module sim_lin_dom_guard;

  localparam int unsigned T = 8;

  logic clk = 1'b0;
  logic por_n, txd_in, txd_driven, cs_in, cs_driven, bus_in;
  logic tx_en, tx_dom, pullup_en, rxd;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  logic m_s1, m_s2;
  int   m_run;

  always #2 clk = ~clk;

  lin_dom_guard #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .txd_in(txd_in), .txd_driven(txd_driven),
    .cs_in(cs_in), .cs_driven(cs_driven), .bus_in(bus_in),
    .tx_en(tx_en), .tx_dom(tx_dom), .pullup_en(pullup_en), .rxd(rxd)
  );

  task automatic chk(input string tag, input string what, input logic act,
                     input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Apply inputs just after a falling edge, compare, then advance the model
  // across the coming rising edge.
  task automatic step(input string tag, input logic por, input logic bus,
                      input logic txd, input logic txdd, input logic cs,
                      input logic csd);
    logic g, cs_r, txd_r, etx;
    por_n = por; bus_in = bus; txd_in = txd; txd_driven = txdd;
    cs_in = cs; cs_driven = csd;
    if (!por) begin m_s1 = 1'b1; m_s2 = 1'b1; m_run = 0; end
    #1;
    cs_r  = csd ? cs : 1'b0;             // R6 fail-safe
    txd_r = txdd ? txd : 1'b1;           // R7 fail-safe
    g     = (m_run >= T) && !m_s2;
    etx   = cs_r && !g;
    chk(tag, "tx_en",     tx_en,     etx);
    chk(tag, "tx_dom",    tx_dom,    etx && !txd_r);
    chk(tag, "pullup_en", pullup_en, !g);
    chk(tag, "rxd",       rxd,       m_s2 || (m_run >= T));
    if (por) begin
      m_run = m_s2 ? 0 : ((m_run < T) ? m_run + 1 : m_run);
      m_s2  = m_s1;
      m_s1  = bus;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_s1 = 1'b1; m_s2 = 1'b1; m_run = 0;
    por_n = 1'b0; bus_in = 1'b1; txd_in = 1'b1; txd_driven = 1'b1;
    cs_in = 1'b1; cs_driven = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 3; i++) step("R10", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R10", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);

    // R1 R2 R3 R8 R9 burst sweep; mode 0 = external node pulls low (R5),
    // mode 1 = local TXD low
    for (int mode = 0; mode < 2; mode++) begin
      for (int len = 0; len <= int'(T) + 4; len++) begin
        for (int k = 0; k < len; k++)
          step(mode == 0 ? "R5" : "R1", 1'b1, 1'b0, mode == 0, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++)
          step("R8", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      end
    end

    // R9 alternating bus pattern
    for (int k = 0; k < 12; k++)
      step("R9", 1'b1, logic'((k >> 1) & 1), 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);

    // R6 R7 pin combinations, idle and while tripped
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1)
        for (int k = 0; k < int'(T) + 3; k++)
          step("R1", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      for (int c = 0; c < 16; c++)
        step(c[0] ? "R6" : "R7", 1'b1, (ph == 0), c[0], c[1], c[2], c[3]);
      for (int k = 0; k < 4; k++) step("R8", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    end

    // R4 reset mid-run discards a partial count
    for (int k = 0; k < int'(T) - 1; k++)
      step("R4", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R4", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < int'(T) + 4; k++)
      step("R4", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R4 one recessive sample inside a long low stretch restarts the count
    for (int k = 0; k < 4; k++) step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < int'(T) - 1; k++)
      step("R4", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < int'(T) + 2; k++)
      step("R4", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) step("R8", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule